// File: doc/BRIEF.md
# Sleep Control and Reset Port Decoder

This block sits on a simple I/O-port request bus and decodes writes and reads to three small registers. The first is a 16-bit power-management control word holding a sleep-type field, a write-only sleep-enable bit and an interrupt-enable flag. The second is a byte-wide command port that can only set or clear that flag. The third is a byte-wide reset control register whose bit 2 starts a system reset on a rising transition.

Each accepted request gets a registered response one cycle later, with an error flag for accesses of the wrong size. Two outputs leave the block as single-cycle pulses: a soft-off request when software arms sleep with the soft-off sleep type, and a reset request that carries the hard/soft selection beside it. Addresses that match none of the three registers are left to other devices on the bus and get no response.

Top module: `sleep_reset_ctl`

## Requirements
- R1: After reset, the control word and reset register read as 0x0000, and poweroff_req, reset_req and reset_hard are low.
- R2: A 16-bit write to the control address (default 0x0404) stores write-data bits 12:2, clears bits 15:13 and 1, and leaves stored bit 0 (interrupt enable) unchanged; a 16-bit read returns the stored word.
- R3: poweroff_req pulses high for one cycle, the cycle after a 16-bit control write in which data bit 13 is 1 and data bits 12:10 equal 5 (SOFTOFF_TYPE); it stays low for any other control write.
- R4: An 8-bit write to the command address (default 0x00B2) with data 0xA0 (CMD_ON) sets control bit 0, with 0xA1 (CMD_OFF) clears it, and with any other value changes nothing; a read of the command address is answered with rsp_err = 1.
- R5: The reset register (address 0x0CF9) accepts 8-bit writes of data bits 7:0 and an 8-bit read returns the last value written in rsp_rdata bits 7:0, with bits 15:8 zero.
- R6: reset_req pulses high for one cycle, the cycle after an 8-bit reset-register write whose bit 2 is 1 while the stored bit 2 is 0; in that cycle reset_hard equals written bit 1 (1 = hard, 0 = soft), and reset_hard is low whenever reset_req is low.
- R7: Size codes are 0 = 8 bit, 1 = 16 bit, 2 = 32 bit; a control access not of size 1 or a command/reset access not of size 0 gets rsp_err = 1, changes no register and raises no request.
- R8: A request to any other address gets no response (rsp_valid stays low) and changes no state.
- R9: A request to a decoded address is answered exactly one cycle later with rsp_valid = 1; rsp_rdata carries the value held before the request for a successful read and is 0 for writes and errored accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Port address |
| req_size | input | 2 | Access size: 0 = byte, 1 = 16 bit, 2 = 32 bit |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response strobe for a decoded request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 16 | Read data |
| poweroff_req | output | 1 | One-cycle soft-off request |
| reset_req | output | 1 | One-cycle system reset request |
| reset_hard | output | 1 | Reset kind during reset_req: 1 hard, 0 soft |

## Verification
The bench targets the sleep-enable bit and its sleep-type gate: a design that stored bit 13 would read it back, and one that checked the old sleep type or ignored bit 13 would pulse soft-off on the wrong writes. It writes the control word repeatedly around command-port toggles to catch a design that lets ordinary writes overwrite the interrupt-enable flag, or that acts on unknown command codes. It repeats reset writes with bit 2 already set and clears it between pulses, so a level-sensitive reset would pulse twice. Wrong-size and unmapped accesses are followed by readbacks that expose any state change they leaked.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } io_size_e;

  localparam int CTRL_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int IE_BIT   = 0;
  localparam int SLP_BIT  = 13;
  localparam int TYPE_LSB = 10;
  localparam int TYPE_W   = 3;
  localparam int RST_GO   = 2;
  localparam int RST_KIND = 1;

  localparam logic [CTRL_W-1:0] CTRL_KEEP_MASK = 16'h1FFC;
endpackage

// File: rtl/sr_decode.sv
module sr_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0404,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'h00B2,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 16'h0CF9
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              hit,
  output logic              bad,
  output logic              wr_ctrl,
  output logic              wr_cmd,
  output logic              wr_rst,
  output logic              rd_ctrl,
  output logic              rd_rst
);
  import sr_pkg::*;

  logic sel_ctrl, sel_cmd, sel_rst;
  logic ok_ctrl, ok_cmd, ok_rst;

  always_comb begin
    sel_ctrl = req_valid && (req_addr == CTRL_ADDR);
    sel_cmd  = req_valid && (req_addr == CMD_ADDR);
    sel_rst  = req_valid && (req_addr == RST_ADDR);
    ok_ctrl  = sel_ctrl && (req_size == SZ_HALF);
    ok_cmd   = sel_cmd && (req_size == SZ_BYTE) && req_write;
    ok_rst   = sel_rst && (req_size == SZ_BYTE);
    hit      = sel_ctrl || sel_cmd || sel_rst;
    bad      = hit && !(ok_ctrl || ok_cmd || ok_rst);
    wr_ctrl  = ok_ctrl && req_write;
    rd_ctrl  = ok_ctrl && !req_write;
    wr_cmd   = ok_cmd;
    wr_rst   = ok_rst && req_write;
    rd_rst   = ok_rst && !req_write;
  end
endmodule

// File: rtl/sr_ctrl_reg.sv
module sr_ctrl_reg #(
  parameter logic [7:0] CMD_ON       = 8'hA0,
  parameter logic [7:0] CMD_OFF      = 8'hA1,
  parameter logic [2:0] SOFTOFF_TYPE = 3'd5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_ctrl,
  input  logic                      wr_cmd,
  input  logic [sr_pkg::CTRL_W-1:0] wdata,
  output logic [sr_pkg::CTRL_W-1:0] ctrl_q,
  output logic                      poweroff_q
);
  import sr_pkg::*;

  logic [TYPE_W-1:0] new_type;
  logic              arm;
  logic              ie_next;

  always_comb begin
    new_type = wdata[TYPE_LSB +: TYPE_W];
    arm      = wdata[SLP_BIT];
    ie_next  = ctrl_q[IE_BIT];
    if (wr_cmd) begin
      if (wdata[BYTE_W-1:0] == CMD_ON)
        ie_next = 1'b1;
      else if (wdata[BYTE_W-1:0] == CMD_OFF)
        ie_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      poweroff_q <= 1'b0;
    end else begin
      poweroff_q <= wr_ctrl && arm && (new_type == SOFTOFF_TYPE);
      if (wr_ctrl)
        ctrl_q <= (wdata & CTRL_KEEP_MASK) | {{(CTRL_W-1){1'b0}}, ctrl_q[IE_BIT]};
      else
        ctrl_q[IE_BIT] <= ie_next;
    end
  end
endmodule

// File: rtl/sr_reset_reg.sv
module sr_reset_reg (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_rst,
  input  logic [sr_pkg::BYTE_W-1:0] wdata,
  output logic [sr_pkg::BYTE_W-1:0] rst_q,
  output logic                      req_q,
  output logic                      hard_q
);
  import sr_pkg::*;

  logic rise;

  always_comb rise = wr_rst && wdata[RST_GO] && !rst_q[RST_GO];

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q  <= '0;
      req_q  <= 1'b0;
      hard_q <= 1'b0;
    end else begin
      req_q  <= rise;
      hard_q <= rise && wdata[RST_KIND];
      if (wr_rst)
        rst_q <= wdata;
    end
  end
endmodule

// File: rtl/sleep_reset_ctl.sv
module sleep_reset_ctl #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0404,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'h00B2,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 16'h0CF9,
  parameter logic [7:0] CMD_ON       = 8'hA0,
  parameter logic [7:0] CMD_OFF      = 8'hA1,
  parameter logic [2:0] SOFTOFF_TYPE = 3'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [15:0]       rsp_rdata,
  output logic              poweroff_req,
  output logic              reset_req,
  output logic              reset_hard
);
  import sr_pkg::*;

  logic hit, bad, wr_ctrl, wr_cmd, wr_rst, rd_ctrl, rd_rst;
  logic [CTRL_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] rst_q;
  logic [CTRL_W-1:0] rd_mux;

  sr_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .CMD_ADDR(CMD_ADDR), .RST_ADDR(RST_ADDR)
  ) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .hit(hit), .bad(bad), .wr_ctrl(wr_ctrl),
    .wr_cmd(wr_cmd), .wr_rst(wr_rst), .rd_ctrl(rd_ctrl), .rd_rst(rd_rst)
  );

  sr_ctrl_reg #(
    .CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF), .SOFTOFF_TYPE(SOFTOFF_TYPE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_cmd(wr_cmd),
    .wdata(req_wdata), .ctrl_q(ctrl_q), .poweroff_q(poweroff_req)
  );

  sr_reset_reg u_rst (
    .clk(clk), .rst(rst), .wr_rst(wr_rst), .wdata(req_wdata[BYTE_W-1:0]),
    .rst_q(rst_q), .req_q(reset_req), .hard_q(reset_hard)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_ctrl)
      rd_mux = ctrl_q;
    else if (rd_rst)
      rd_mux = {{(CTRL_W-BYTE_W){1'b0}}, rst_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= hit;
      rsp_err   <= bad;
      rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0404,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'h00B2,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 16'h0CF9
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [15:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [15:0]       rsp_rdata,
  input logic              poweroff_req,
  input logic              reset_req,
  input logic              reset_hard,
  input logic [15:0]       ctrl_q
);
  AST_CTRL_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[15:13] == 3'b0) && !ctrl_q[1]) else $error("ctrl bits"); // R2

  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    poweroff_req |-> $past(req_valid && req_write && req_addr == CTRL_ADDR &&
      req_size == 2'd1 && req_wdata[13] && req_wdata[12:10] == 3'd5))
    else $error("off cause"); // R3

  AST_CMD_READ_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr == CMD_ADDR) |=> (rsp_valid && rsp_err))
    else $error("cmd read"); // R4

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(req_valid && req_write && req_addr == RST_ADDR &&
      req_size == 2'd0 && req_wdata[2]))
    else $error("rst cause"); // R6

  AST_HARD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !reset_req |-> !reset_hard) else $error("hard quiet"); // R6

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (!poweroff_req && !reset_req && rsp_rdata == 16'h0))
    else $error("err req"); // R7

  AST_RSP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid)) else $error("rsp timing"); // R9
endmodule

bind sleep_reset_ctl sr_checker #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CMD_ADDR(CMD_ADDR), .RST_ADDR(RST_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .poweroff_req(poweroff_req), .reset_req(reset_req), .reset_hard(reset_hard),
  .ctrl_q(ctrl_q)
);

// File: tb/sleep_reset_ctl_tb_top.sv
`timescale 1ns/100ps
module sleep_reset_ctl_tb_top;
  localparam logic [15:0] A_CTRL = 16'h0404;
  localparam logic [15:0] A_CMD  = 16'h00B2;
  localparam logic [15:0] A_RST  = 16'h0CF9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid, rsp_err, poweroff_req, reset_req, reset_hard;
  logic [15:0] rsp_rdata;

  always #2.5 clk = ~clk;

  sleep_reset_ctl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .poweroff_req(poweroff_req), .reset_req(reset_req), .reset_hard(reset_hard)
  );

  int vectors = 0;
  int miscompares = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R1";
  string e_tag = "R1";

  // behavioural reference state
  int m_ctrl = 0;
  int m_rst = 0;
  int e_valid = 0, e_err = 0, e_rd = 0, e_off = 0, e_rr = 0, e_hard = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    e_tag = cur_req;
    e_valid = 0; e_err = 0; e_rd = 0; e_off = 0; e_rr = 0; e_hard = 0;
    if (rst) begin
      m_ctrl = 0;
      m_rst = 0;
    end else if (req_valid) begin
      if (req_addr == A_CTRL) begin
        e_valid = 1;
        if (req_size != 2'd1) e_err = 1;
        else if (req_write) begin
          if (req_wdata[13] && req_wdata[12:10] == 3'd5) e_off = 1;
          m_ctrl = (int'(req_wdata) & 'h1FFC) + (m_ctrl % 2);
        end else e_rd = m_ctrl;
      end else if (req_addr == A_CMD) begin
        e_valid = 1;
        if (req_size != 2'd0 || !req_write) e_err = 1;
        else if (req_wdata[7:0] == 8'hA0) m_ctrl = m_ctrl | 1;
        else if (req_wdata[7:0] == 8'hA1) m_ctrl = m_ctrl & ~1;
      end else if (req_addr == A_RST) begin
        e_valid = 1;
        if (req_size != 2'd0) e_err = 1;
        else if (req_write) begin
          if (req_wdata[2] && ((m_rst / 4) % 2 == 0)) begin
            e_rr = 1;
            e_hard = int'(req_wdata[1]);
          end
          m_rst = int'(req_wdata[7:0]);
        end else e_rd = m_rst;
      end
    end
  end

  task automatic cmp(string what, int got, int exp);
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", e_tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      cmp("rsp_valid", int'(rsp_valid), e_valid);
      cmp("rsp_err", int'(rsp_err), e_err);
      cmp("rsp_rdata", int'(rsp_rdata), e_rd);
      cmp("poweroff_req", int'(poweroff_req), e_off);
      cmp("reset_req", int'(reset_req), e_rr);
      cmp("reset_hard", int'(reset_hard), e_hard);
    end
  end

  task automatic xact(string tag, bit w, logic [15:0] a, logic [1:0] sz, logic [15:0] d);
    @(negedge clk);
    cur_req = tag;
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic burst(string tag, bit w, logic [15:0] a, logic [1:0] sz, logic [15:0] d);
    @(negedge clk);
    cur_req = tag;
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    xact("R1", 0, A_CTRL, 2'd1, 16'h0);
    xact("R1", 0, A_RST, 2'd0, 16'h0);
    // R2 masking, R3 gating
    xact("R2", 1, A_CTRL, 2'd1, 16'hFFFF);
    xact("R2", 0, A_CTRL, 2'd1, 16'h0);
    xact("R3", 1, A_CTRL, 2'd1, 16'h3400);
    xact("R3", 1, A_CTRL, 2'd1, 16'h1400);
    xact("R3", 1, A_CTRL, 2'd1, 16'h2C00);
    xact("R3", 1, A_CTRL, 2'd1, 16'h3800);
    xact("R2", 0, A_CTRL, 2'd1, 16'h0);
    // R4 command port
    xact("R4", 1, A_CMD, 2'd0, 16'h00A0);
    xact("R4", 0, A_CTRL, 2'd1, 16'h0);
    xact("R2", 1, A_CTRL, 2'd1, 16'h0000);
    xact("R2", 0, A_CTRL, 2'd1, 16'h0);
    xact("R4", 1, A_CMD, 2'd0, 16'h0055);
    xact("R4", 0, A_CTRL, 2'd1, 16'h0);
    xact("R4", 1, A_CMD, 2'd0, 16'h00A1);
    xact("R4", 0, A_CTRL, 2'd1, 16'h0);
    xact("R4", 0, A_CMD, 2'd0, 16'h0);
    xact("R4", 1, A_CMD, 2'd0, 16'h00A0);
    xact("R4", 1, A_CMD, 2'd0, 16'h01A1);
    xact("R4", 0, A_CTRL, 2'd1, 16'h0);
    // R7 wrong sizes
    xact("R7", 1, A_CTRL, 2'd0, 16'h3400);
    xact("R7", 1, A_CTRL, 2'd2, 16'h3400);
    xact("R7", 0, A_CTRL, 2'd1, 16'h0);
    xact("R7", 1, A_RST, 2'd1, 16'h0004);
    xact("R7", 1, A_CMD, 2'd1, 16'h00A1);
    xact("R7", 0, A_CTRL, 2'd1, 16'h0);
    xact("R7", 0, A_RST, 2'd0, 16'h0);
    // R5 / R6 reset register
    xact("R6", 1, A_RST, 2'd0, 16'h0006);
    xact("R6", 1, A_RST, 2'd0, 16'h0006);
    xact("R5", 0, A_RST, 2'd0, 16'h0);
    xact("R6", 1, A_RST, 2'd0, 16'h0000);
    xact("R6", 1, A_RST, 2'd0, 16'h0004);
    xact("R6", 1, A_RST, 2'd0, 16'h0002);
    xact("R5", 1, A_RST, 2'd0, 16'hFFFB);
    xact("R5", 0, A_RST, 2'd0, 16'h0);
    // R8 unmapped
    xact("R8", 1, 16'h0405, 2'd1, 16'h3400);
    xact("R8", 1, 16'h0CF8, 2'd0, 16'h0004);
    xact("R8", 0, A_CTRL, 2'd1, 16'h0);
    // R9 back-to-back
    burst("R9", 1, A_CTRL, 2'd1, 16'h3400);
    burst("R9", 1, A_CTRL, 2'd1, 16'h3400);
    burst("R9", 0, A_CTRL, 2'd1, 16'h0);
    burst("R9", 1, A_RST, 2'd0, 16'h0000);
    burst("R9", 1, A_RST, 2'd0, 16'h0006);
    burst("R9", 0, A_RST, 2'd0, 16'h0);
    xact("R9", 1, A_CMD, 2'd0, 16'h00A0);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, d;
      logic [1:0] sz;
      int pick;
      pick = $urandom_range(0, 4);
      a = (pick == 0) ? A_CTRL : (pick == 1) ? A_CMD : (pick == 2) ? A_RST :
          (pick == 3) ? A_CTRL : 16'($urandom_range(0, 65535));
      sz = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 2)) :
           ((a == A_CTRL) ? 2'd1 : 2'd0);
      d = 16'($urandom_range(0, 65535));
      if ($urandom_range(0, 1) == 1) d[12:10] = 3'd5;
      if (a == A_CMD && $urandom_range(0, 1) == 1) d[7:0] = 8'hA0 + 8'($urandom_range(0, 1));
      burst("R9", 1'($urandom_range(0, 1)), a, sz, d);
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1 synchronous reset clears state mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    xact("R1", 0, A_CTRL, 2'd1, 16'h0);
    xact("R1", 0, A_RST, 2'd0, 16'h0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule